// File: doc/BRIEF.md
# Refresh Insertion Boundary Scheduler

This block sits between a DRAM command sequencer and the command bus. It decides the exact cycle in which a pending refresh may be placed on the bus. A refresh-interval timer sends a one-cycle request, and the block latches it. The block then waits for a boundary that the selected insertion policy allows, fires a one-cycle issue strobe, and holds a stall to the sequencer for a programmable refresh recovery time.

Two insertion policies exist. In the burst policy, a refresh may cut into a running command at the next burst boundary. In the command policy, the refresh waits for the end of the command. The exception is a transaction that crosses a page: there the refresh may go out at the end of the current page. After such a page cut, the block raises a resume pulse once the stall is over, so the sequencer can reopen the next page. When the sequencer is idle, a pending refresh goes out at once in either policy.

Top module: `refresh_boundary_sched`

## Requirements
- R1: After reset, `refresh_issue`, `stall`, `resume` and `postponed_cnt` are all 0, and the burst policy (mode 0) is in force.
- R2: When `seq_busy` is 0, a refresh requested in cycle N is issued in cycle N+1, whatever the policy.
- R3: In mode 0 with `seq_busy` at 1, a pending refresh is issued in the same cycle as `burst_end`. `cmd_end` and `page_end` alone do not issue it.
- R4: In mode 1 with `txn_in_page` at 1 and `seq_busy` at 1, a pending refresh is issued only in a cycle where `cmd_end` is 1. `burst_end` and `page_end` alone do not issue it.
- R5: In mode 1 with `txn_in_page` at 0 and `seq_busy` at 1, a pending refresh is issued in a cycle where `page_end` or `cmd_end` is 1. `burst_end` alone does not issue it.
- R6: `stall` is high from the issue cycle for max(`trfc_cycles`,1) consecutive cycles, and no further refresh is issued while it is high.
- R7: A request is held pending until it is issued. A request that arrives while one is pending and is not being issued raises `postponed_cnt` by one. The count saturates at 7.
- R8: The policy bit `mode_sel` is taken only in cycles with no refresh pending. A change made during a wait does not alter that wait.
- R9: When a refresh is issued in mode 1 at a `page_end` without `cmd_end` in a page-crossing transaction, `resume` is high for exactly one cycle: the first cycle after the stall ends. No other issue produces a `resume`.
- R10: No two issue strobes occur without a request between them. A single request yields exactly one issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_req | input | 1 | One-cycle refresh request from the interval timer |
| mode_sel | input | 1 | Insertion policy: 0 burst boundary, 1 command or page boundary |
| trfc_cycles | input | 8 | Refresh recovery time in cycles (0 acts as 1) |
| seq_busy | input | 1 | A transaction is in progress in the sequencer |
| burst_end | input | 1 | Current cycle ends a DRAM burst |
| cmd_end | input | 1 | Current cycle ends a command |
| page_end | input | 1 | Current cycle ends an open page |
| txn_in_page | input | 1 | Current transaction lies wholly inside one page |
| refresh_issue | output | 1 | One-cycle strobe: refresh goes out now |
| stall | output | 1 | Blocks new bursts from the sequencer |
| resume | output | 1 | One-cycle pulse telling the sequencer to reopen the next page |
| postponed_cnt | output | 3 | Saturating count of requests merged into a pending one |

## Verification
The assertions take for granted that the boundary strobes come only while `seq_busy` is high. They also assume that `txn_in_page` stays constant while a refresh waits, and that `trfc_cycles` does not change while a stall is running. The bench drives every strobe, mode and page combination from an idle state. It raises `seq_busy` before each strobe and sets `txn_in_page` and `trfc_cycles` only while nothing is pending or stalled. Each case is flushed by dropping `seq_busy`, so no wait is left open when the inputs change.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
   typedef enum logic {
      INS_BURST = 1'b0,
      INS_CMD   = 1'b1
   } ins_mode_e;
endpackage

// File: rtl/rbs_pending.sv
module rbs_pending #(
   parameter int CNT_W    = 3,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             issue,
   output logic             pending_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("rbs_pending: CNT_W must be at least 1");
      end
   endgenerate

   logic             pend_q;
   logic [CNT_W-1:0] cnt_q;
   logic             merge;

   assign merge = req & pend_q & ~issue;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= (pend_q & ~issue) | req;
   end

   generate
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n)                         cnt_q <= '0;
            else if (merge && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)     cnt_q <= '0;
            else if (merge) cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate

   assign pending_o = pend_q;
   assign cnt_o     = cnt_q;

   // R7
   cnt_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SATURATE && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
   // R7
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !issue) |=> pend_q);
endmodule

// File: rtl/rbs_policy.sv
module rbs_policy
   import rbs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic mode_in,
   input  logic pending,
   input  logic stall_busy,
   input  logic seq_busy,
   input  logic burst_end,
   input  logic cmd_end,
   input  logic page_end,
   input  logic txn_in_page,
   output logic issue_o,
   output logic page_cut_o
);
   ins_mode_e mode_q;
   logic      at_bound;

   always_ff @(posedge clk) begin
      if (!rst_n)        mode_q <= INS_BURST;
      else if (!pending) mode_q <= ins_mode_e'(mode_in);
   end

   always_comb begin
      at_bound = 1'b0;
      unique case (mode_q)
         INS_BURST: at_bound = burst_end;
         INS_CMD:   at_bound = txn_in_page ? cmd_end : (cmd_end | page_end);
         default:   at_bound = 1'b0;
      endcase
   end

   assign issue_o    = pending & ~stall_busy & (~seq_busy | at_bound);
   assign page_cut_o = issue_o & seq_busy & (mode_q == INS_CMD)
                       & ~txn_in_page & page_end & ~cmd_end;

   // R8
   mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && $past(pending)) |-> $stable(mode_q));
   // R3
   burst_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_o && seq_busy && mode_q == INS_BURST) |-> burst_end);
   // R4
   inpage_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_o && seq_busy && mode_q == INS_CMD && txn_in_page) |-> cmd_end);
endmodule

// File: rtl/rbs_stall.sv
module rbs_stall #(
   parameter int TRFC_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic              page_cut,
   input  logic [TRFC_W-1:0] trfc,
   output logic              stall_o,
   output logic              busy_o,
   output logic              resume_o
);
   generate
      if (TRFC_W < 1) begin : g_bad_w
         $error("rbs_stall: TRFC_W must be at least 1");
      end
   endgenerate

   logic [TRFC_W-1:0] cnt_q;
   logic              cut_q;

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt_q <= '0;
      else if (issue)       cnt_q <= (trfc == '0) ? '0 : trfc - 1'b1;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o   = (cnt_q != '0);
   assign stall_o  = issue | busy_o;
   assign resume_o = cut_q & ~stall_o;

   always_ff @(posedge clk) begin
      if (!rst_n)                cut_q <= 1'b0;
      else if (issue & page_cut) cut_q <= 1'b1;
      else if (resume_o)         cut_q <= 1'b0;
   end

   // R6
   no_issue_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !issue);
   // R6
   stall_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && trfc > 1) |=> stall_o);
   // R9
   resume_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resume_o |=> !resume_o);
endmodule

// File: rtl/refresh_boundary_sched.sv
module refresh_boundary_sched #(
   parameter int TRFC_W = 8,
   parameter int PCNT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              refresh_req,
   input  logic              mode_sel,
   input  logic [TRFC_W-1:0] trfc_cycles,
   input  logic              seq_busy,
   input  logic              burst_end,
   input  logic              cmd_end,
   input  logic              page_end,
   input  logic              txn_in_page,
   output logic              refresh_issue,
   output logic              stall,
   output logic              resume,
   output logic [PCNT_W-1:0] postponed_cnt
);
   logic pending;
   logic stall_busy;
   logic page_cut;

   rbs_pending #(.CNT_W(PCNT_W), .SATURATE(1'b1)) pend_i (
      .clk(clk), .rst_n(rst_n), .req(refresh_req), .issue(refresh_issue),
      .pending_o(pending), .cnt_o(postponed_cnt)
   );

   rbs_policy pol_i (
      .clk(clk), .rst_n(rst_n), .mode_in(mode_sel), .pending(pending),
      .stall_busy(stall_busy), .seq_busy(seq_busy), .burst_end(burst_end),
      .cmd_end(cmd_end), .page_end(page_end), .txn_in_page(txn_in_page),
      .issue_o(refresh_issue), .page_cut_o(page_cut)
   );

   rbs_stall #(.TRFC_W(TRFC_W)) stall_i (
      .clk(clk), .rst_n(rst_n), .issue(refresh_issue), .page_cut(page_cut),
      .trfc(trfc_cycles), .stall_o(stall), .busy_o(stall_busy),
      .resume_o(resume)
   );

   // R10
   issue_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_issue |-> pending);
   // R10
   single_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_issue && !refresh_req) |=> !refresh_issue);
endmodule

// File: tb/refresh_boundary_sched_tb_top.sv
module refresh_boundary_sched_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       refresh_req = 1'b0, mode_sel = 1'b0, seq_busy = 1'b0;
   logic       burst_end = 1'b0, cmd_end = 1'b0, page_end = 1'b0;
   logic       txn_in_page = 1'b0;
   logic [7:0] trfc_cycles = 8'd1;
   logic       refresh_issue, stall, resume;
   logic [2:0] postponed_cnt;
   int         total = 0, bad = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   refresh_boundary_sched dut_i (
      .clk(clk), .rst_n(rst_n), .refresh_req(refresh_req), .mode_sel(mode_sel),
      .trfc_cycles(trfc_cycles), .seq_busy(seq_busy), .burst_end(burst_end),
      .cmd_end(cmd_end), .page_end(page_end), .txn_in_page(txn_in_page),
      .refresh_issue(refresh_issue), .stall(stall), .resume(resume),
      .postponed_cnt(postponed_cnt)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // advance to the next negedge, clear strobes; outputs are read after #1
   task automatic cyc();
      @(negedge clk);
      refresh_req = 1'b0; burst_end = 1'b0; cmd_end = 1'b0; page_end = 1'b0;
   endtask

   // from the issue cycle (already sampled), walk the stall window
   task automatic walk_stall(input int len, input bit cut, input string req);
      for (int k = 1; k <= len; k++) begin
         cyc(); #1;
         chk({req, " stall"}, stall, (k < len) ? 1 : 0);
         chk({req, " no re-issue"}, refresh_issue, 0);
         chk("R9 resume", resume, (k == len) ? int'(cut) : 0);
      end
      cyc(); #1;
      chk("R9 resume one cycle", resume, 0);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=1 expected=0");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk("R1 issue", refresh_issue, 0);
      chk("R1 stall", stall, 0);
      chk("R1 resume", resume, 0);
      chk("R1 postponed", postponed_cnt, 0);
      rst_n = 1'b1;

      // R2: idle issue, trfc sweep for R6
      for (int t = 0; t <= 4; t++) begin
         for (int m = 0; m < 2; m++) begin
            cyc(); trfc_cycles = 8'(t); mode_sel = m[0]; seq_busy = 1'b0;
            refresh_req = 1'b1; #1;
            chk("R2 not same cycle", refresh_issue, 0);
            cyc(); #1;
            chk("R2 idle issue next", refresh_issue, 1);
            chk("R6 stall at issue", stall, 1);
            walk_stall((t == 0) ? 1 : t, 1'b0, "R6");
         end
      end

      // R3 R4 R5 R9: sweep mode x page x strobe
      for (int m = 0; m < 2; m++)
         for (int ip = 0; ip < 2; ip++)
            for (int s = 0; s < 3; s++) begin
               automatic bit exp = (m == 0) ? (s == 0)
                                  : (ip == 1) ? (s == 1) : (s != 0);
               automatic bit cut = (m == 1) && (ip == 0) && (s == 2);
               automatic string rq = (m == 0) ? "R3" : (ip == 1) ? "R4" : "R5";
               cyc(); mode_sel = m[0]; txn_in_page = ip[0]; trfc_cycles = 8'd3;
               seq_busy = 1'b1; refresh_req = 1'b1; #1;
               chk({rq, " no early"}, refresh_issue, 0);
               cyc(); #1;
               chk({rq, " waits"}, refresh_issue, 0);
               cyc();
               burst_end = (s == 0); cmd_end = (s == 1); page_end = (s == 2); #1;
               chk({rq, " boundary"}, refresh_issue, int'(exp));
               if (!exp) begin
                  cyc(); seq_busy = 1'b0; #1;
                  chk("R2 flush", refresh_issue, 1);
               end
               walk_stall(3, cut, rq);
               seq_busy = 1'b0;
            end

      // R8: mode change during a wait has no effect
      cyc(); mode_sel = 1'b1; txn_in_page = 1'b1; trfc_cycles = 8'd1;
      seq_busy = 1'b1; refresh_req = 1'b1;
      cyc(); mode_sel = 1'b0;
      cyc(); burst_end = 1'b1; #1;
      chk("R8 old mode kept", refresh_issue, 0);
      cyc(); cmd_end = 1'b1; #1;
      chk("R8 old mode issues", refresh_issue, 1);
      cyc(); seq_busy = 1'b0;

      // R7 R10: merged requests counted, saturating; one issue only
      cyc(); mode_sel = 1'b0; seq_busy = 1'b1; refresh_req = 1'b1;
      for (int n = 1; n <= 9; n++) begin
         cyc(); refresh_req = 1'b1; #1;
         chk("R7 postponed", postponed_cnt, (n - 1 > 7) ? 7 : n - 1);
         chk("R7 held", refresh_issue, 0);
      end
      cyc(); #1;
      chk("R7 saturate", postponed_cnt, 7);
      cyc(); burst_end = 1'b1; #1;
      chk("R7 issue", refresh_issue, 1);
      cyc(); seq_busy = 1'b0; #1;
      chk("R10 single issue", refresh_issue, 0);
      cyc(); #1;
      chk("R10 still none", refresh_issue, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule